// File: doc/BRIEF.md
# USB Device Global NAK Controller

This block holds the device-control word of a USB 2.0 high-speed device core and makes the handshake decision for every token the core receives. Software reaches the word through a single-register bus: a write strobe with a 32-bit data word, and a read path that always shows the current value. The word carries write-only strobes that raise or lower two global NAK states, one for all OUT endpoints and one for all non-periodic IN endpoints. It also carries a read-only copy of the OUT NAK state, a 3-bit test-mode field and a flag that software sets when it has finished programming after power-up.

For each token the block chooses one of ACK, NAK, STALL or a silent drop, and says whether the payload may go into the receive FIFO. It combines the global NAK states with the endpoint's own STALL and NAK settings and with the free FIFO space. A global OUT NAK answers every OUT packet with NAK, but SETUP packets are exempt and isochronous OUT data is dropped. The core raises the IN NAK by itself when the transaction layer reports a timeout on a non-periodic endpoint.

The token side is a valid-only stream with no back-pressure. The block accepts a token in every cycle that `tok_valid` is high and produces one registered decision per token, exactly one cycle later. The sender must not expect a stall signal.

Top module: `usb_gnak_ctrl`

## Requirements
- R1: Read data bits [31:12], [10:7] and [2:0] are always 0. Bit 11 is a read/write programming-done flag, and it is 0 after reset.
- R2: A write with bit 9 set raises the global OUT NAK, and a write with bit 10 set lowers it. When both bits are set in the same write, the lower request wins.
- R3: A write with bit 7 set raises the global non-periodic IN NAK, and a write with bit 8 set lowers it. When both bits are set in the same write, the lower request wins.
- R4: Read bit 3 equals the global OUT NAK state, and it is 0 after reset.
- R5: While the OUT NAK is raised, an OUT token (kind 0) with iso=0 gets NAK (code 1), whatever the endpoint STALL setting. An OUT token with iso=1 gets DROP (code 3). Neither enables a FIFO write.
- R6: A SETUP token (kind 1) always gets ACK (code 0) with the FIFO write enabled. This holds regardless of either global NAK, the endpoint bits or the free space.
- R7: While the OUT NAK is lowered, an OUT token gets the first matching answer from this list: STALL (code 2) if the endpoint is stalled; NAK if the endpoint NAK is set; NAK if free space is less than the length. Otherwise it gets ACK with the FIFO write enabled, and free space equal to the length is enough.
- R8: While the IN NAK is raised, an IN token (kind 2) with periodic=0 gets NAK. Periodic IN tokens and OUT tokens are unaffected by the IN NAK.
- R9: Any other IN token gets STALL if the endpoint is stalled, otherwise NAK if the endpoint NAK is set, otherwise ACK. An IN token never enables a FIFO write.
- R10: A cycle with `np_timeout` high raises the IN NAK. A write in that same cycle that lowers the IN NAK wins.
- R11: Bits [6:4] are a read/write test-mode field that is 0 after reset. `test_sel` shows the codes 0 to 5 unchanged and shows 0 for the reserved codes 6 and 7, while the field still reads back as written.
- R12: `resp_valid` is high exactly one cycle after `tok_valid`. The decision uses the NAK states as they stood before any write or timeout in the token's cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word read data |
| np_timeout | input | 1 | Timeout seen on a non-periodic endpoint |
| tok_valid | input | 1 | Token present this cycle |
| tok_kind | input | 2 | 0 OUT, 1 SETUP, 2 IN |
| tok_iso | input | 1 | Endpoint is isochronous |
| tok_periodic | input | 1 | IN endpoint is periodic |
| tok_len | input | LEN_W | Packet length in bytes |
| rx_free | input | LEN_W | Free receive FIFO space in bytes |
| ep_stall | input | 1 | Endpoint STALL setting |
| ep_nak | input | 1 | Endpoint NAK setting |
| resp_valid | output | 1 | Decision present |
| resp_code | output | 2 | 0 ACK, 1 NAK, 2 STALL, 3 DROP |
| resp_fifo_wr | output | 1 | Payload may be written to the FIFO |
| out_nak_on | output | 1 | Global OUT NAK state |
| in_nak_on | output | 1 | Global non-periodic IN NAK state |
| test_sel | output | 3 | Effective test mode |

## Verification
On every cycle, the assertions check the following: the set and clear priorities of both NAK states, the timeout raise, the zero reserved read bits, the status mirror, the one-cycle response, the SETUP exemption, the blocked FIFO write under OUT NAK, the IN NAK answer, and the range of the effective test mode. Only the bench's scenarios can show the full OUT and IN priority orders across endpoint bits and FIFO space. The same holds for the exact FIFO-space boundary, the read-back of reserved test codes, the programming-done flag and the exact cycle in which a write becomes visible to a token.

// File: rtl/usb_gnak_pkg.sv
package usb_gnak_pkg;
  typedef enum logic [1:0] {
    TK_OUT   = 2'd0,
    TK_SETUP = 2'd1,
    TK_IN    = 2'd2
  } tok_kind_e;

  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2,
    HS_DROP  = 2'd3
  } hs_e;

  localparam int CW_W       = 32;
  localparam int BIT_IN_SET = 7;
  localparam int BIT_IN_CLR = 8;
  localparam int BIT_OUT_SET = 9;
  localparam int BIT_OUT_CLR = 10;
  localparam int BIT_PRG    = 11;
  localparam int BIT_OSTS   = 3;
  localparam int TST_LO     = 4;
  localparam int TST_W      = 3;
  localparam int TST_MAX    = 5;
  localparam int NFLAG      = 2;
  localparam int FLAG_OUT   = 0;
  localparam int FLAG_IN    = 1;
endpackage

// File: rtl/gnak_ctrl_reg.sv
module gnak_ctrl_reg
  import usb_gnak_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CW_W-1:0]  wdata,
  input  logic             hw_in_set,
  output logic [CW_W-1:0]  rdata,
  output logic             out_nak,
  output logic             in_nak,
  output logic [TST_W-1:0] test_raw
);
  localparam int SET_POS [NFLAG] = '{BIT_OUT_SET, BIT_IN_SET};
  localparam int CLR_POS [NFLAG] = '{BIT_OUT_CLR, BIT_IN_CLR};

  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] hw_set;
  logic             prg_q;

  assign hw_set = {hw_in_set, 1'b0};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic sw_set, sw_clr;
    assign sw_set = wr && wdata[SET_POS[g]];
    assign sw_clr = wr && wdata[CLR_POS[g]];
    always_ff @(posedge clk) begin
      if (!rst_n)                      flag_q[g] <= 1'b0;
      else if (sw_clr)                 flag_q[g] <= 1'b0;
      else if (sw_set || hw_set[g])    flag_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prg_q    <= 1'b0;
      test_raw <= '0;
    end else if (wr) begin
      prg_q    <= wdata[BIT_PRG];
      test_raw <= wdata[TST_LO +: TST_W];
    end
  end

  assign out_nak = flag_q[FLAG_OUT];
  assign in_nak  = flag_q[FLAG_IN];

  always_comb begin
    rdata                   = '0;
    rdata[BIT_PRG]          = prg_q;
    rdata[TST_LO +: TST_W]  = test_raw;
    rdata[BIT_OSTS]         = out_nak;
  end
endmodule

// File: rtl/gnak_test_decode.sv
module gnak_test_decode
  import usb_gnak_pkg::*;
(
  input  logic [TST_W-1:0] raw,
  output logic [TST_W-1:0] sel
);
  always_comb begin
    if (int'(raw) > TST_MAX) sel = '0;
    else                     sel = raw;
  end
endmodule

// File: rtl/gnak_decide.sv
module gnak_decide
  import usb_gnak_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             out_nak,
  input  logic             in_nak,
  input  logic [1:0]       kind,
  input  logic             iso,
  input  logic             periodic,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] free,
  input  logic             stall,
  input  logic             epnak,
  output hs_e              code,
  output logic             fifo_wr
);
  logic room;
  assign room = (free >= len);

  always_comb begin
    code    = HS_NAK;
    fifo_wr = 1'b0;
    unique case (kind)
      TK_SETUP: begin
        code    = HS_ACK;
        fifo_wr = 1'b1;
      end
      TK_OUT: begin
        if (out_nak)    code = iso ? HS_DROP : HS_NAK;
        else if (stall) code = HS_STALL;
        else if (epnak) code = HS_NAK;
        else if (!room) code = HS_NAK;
        else begin
          code    = HS_ACK;
          fifo_wr = 1'b1;
        end
      end
      TK_IN: begin
        if (in_nak && !periodic) code = HS_NAK;
        else if (stall)          code = HS_STALL;
        else if (epnak)          code = HS_NAK;
        else                     code = HS_ACK;
      end
      default: begin
        code    = HS_NAK;
        fifo_wr = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/usb_gnak_ctrl.sv
module usb_gnak_ctrl
  import usb_gnak_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [31:0]      ctl_wdata,
  output logic [31:0]      ctl_rdata,
  input  logic             np_timeout,
  input  logic             tok_valid,
  input  logic [1:0]       tok_kind,
  input  logic             tok_iso,
  input  logic             tok_periodic,
  input  logic [LEN_W-1:0] tok_len,
  input  logic [LEN_W-1:0] rx_free,
  input  logic             ep_stall,
  input  logic             ep_nak,
  output logic             resp_valid,
  output logic [1:0]       resp_code,
  output logic             resp_fifo_wr,
  output logic             out_nak_on,
  output logic             in_nak_on,
  output logic [2:0]       test_sel
);
  logic [TST_W-1:0] test_raw;
  hs_e              dec_code;
  logic             dec_wr;

  gnak_ctrl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctl_wr),
    .wdata    (ctl_wdata),
    .hw_in_set(np_timeout),
    .rdata    (ctl_rdata),
    .out_nak  (out_nak_on),
    .in_nak   (in_nak_on),
    .test_raw (test_raw)
  );

  gnak_test_decode u_tst (
    .raw(test_raw),
    .sel(test_sel)
  );

  gnak_decide #(.LEN_W(LEN_W)) u_dec (
    .out_nak (out_nak_on),
    .in_nak  (in_nak_on),
    .kind    (tok_kind),
    .iso     (tok_iso),
    .periodic(tok_periodic),
    .len     (tok_len),
    .free    (rx_free),
    .stall   (ep_stall),
    .epnak   (ep_nak),
    .code    (dec_code),
    .fifo_wr (dec_wr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid   <= 1'b0;
      resp_code    <= HS_ACK;
      resp_fifo_wr <= 1'b0;
    end else begin
      resp_valid   <= tok_valid;
      resp_code    <= tok_valid ? dec_code : HS_ACK;
      resp_fifo_wr <= tok_valid && dec_wr;
    end
  end
endmodule

// File: rtl/usb_gnak_ctrl_chk.sv
module usb_gnak_ctrl_chk
  import usb_gnak_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr,
  input logic [31:0] ctl_wdata,
  input logic [31:0] ctl_rdata,
  input logic        np_timeout,
  input logic        tok_valid,
  input logic [1:0]  tok_kind,
  input logic        tok_periodic,
  input logic        resp_valid,
  input logic [1:0]  resp_code,
  input logic        resp_fifo_wr,
  input logic        out_nak_on,
  input logic        in_nak_on,
  input logic [2:0]  test_sel
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[31:12] == '0 && ctl_rdata[10:7] == '0 && ctl_rdata[2:0] == '0); // R1
  AST_OUT_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_wdata[10] |=> !out_nak_on); // R2
  AST_OUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_wdata[9] && !ctl_wdata[10] |=> out_nak_on); // R2
  AST_IN_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_wdata[8] |=> !in_nak_on); // R3
  AST_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_wdata[7] && !ctl_wdata[8] |=> in_nak_on); // R3
  AST_STS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[3] == out_nak_on); // R4
  AST_GNAK_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && out_nak_on && tok_kind == TK_OUT |=> !resp_fifo_wr && resp_code != HS_ACK); // R5
  AST_SETUP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && tok_kind == TK_SETUP |=> resp_code == HS_ACK && resp_fifo_wr); // R6
  AST_IN_GNAK: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && in_nak_on && tok_kind == TK_IN && !tok_periodic |=> resp_code == HS_NAK); // R8
  AST_IN_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && tok_kind == TK_IN |=> !resp_fifo_wr); // R9
  AST_TIMEOUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    np_timeout && !(ctl_wr && ctl_wdata[8]) |=> in_nak_on); // R10
  AST_TEST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(test_sel) <= TST_MAX); // R11
  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |=> resp_valid); // R12
  AST_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |=> !resp_valid && !resp_fifo_wr); // R12
endmodule

bind usb_gnak_ctrl usb_gnak_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_wr      (ctl_wr),
  .ctl_wdata   (ctl_wdata),
  .ctl_rdata   (ctl_rdata),
  .np_timeout  (np_timeout),
  .tok_valid   (tok_valid),
  .tok_kind    (tok_kind),
  .tok_periodic(tok_periodic),
  .resp_valid  (resp_valid),
  .resp_code   (resp_code),
  .resp_fifo_wr(resp_fifo_wr),
  .out_nak_on  (out_nak_on),
  .in_nak_on   (in_nak_on),
  .test_sel    (test_sel)
);

// File: tb/usb_gnak_ctrl_tb.sv
module usb_gnak_ctrl_tb;
  localparam int LEN_W = 11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ctl_wr = 1'b0;
  logic [31:0]      ctl_wdata = '0;
  logic [31:0]      ctl_rdata;
  logic             np_timeout = 1'b0;
  logic             tok_valid = 1'b0;
  logic [1:0]       tok_kind = '0;
  logic             tok_iso = 1'b0;
  logic             tok_periodic = 1'b0;
  logic [LEN_W-1:0] tok_len = '0;
  logic [LEN_W-1:0] rx_free = '0;
  logic             ep_stall = 1'b0;
  logic             ep_nak = 1'b0;
  logic             resp_valid;
  logic [1:0]       resp_code;
  logic             resp_fifo_wr;
  logic             out_nak_on;
  logic             in_nak_on;
  logic [2:0]       test_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  usb_gnak_ctrl #(.LEN_W(LEN_W)) u_dut (.*);

  typedef struct packed {
    logic       go;
    logic       gi;
    logic [1:0] kind;
    logic       iso;
    logic       per;
    logic       st;
    logic       nk;
    logic [10:0] len;
    logic [10:0] free;
    logic [1:0] code;
    logic       wr;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,11'd64,11'd100,2'd0,1'b1}, // R7 ack
    '{1'b0,1'b0,2'd0,1'b0,1'b0,1'b1,1'b1,11'd64,11'd100,2'd2,1'b0}, // R7 stall first
    '{1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b1,11'd64,11'd100,2'd1,1'b0}, // R7 ep nak
    '{1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,11'd64,11'd63, 2'd1,1'b0}, // R7 no room
    '{1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,11'd64,11'd64, 2'd0,1'b1}, // R7 exact fit
    '{1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,11'd64,11'd100,2'd1,1'b0}, // R5 nak
    '{1'b1,1'b0,2'd0,1'b1,1'b0,1'b0,1'b0,11'd64,11'd100,2'd3,1'b0}, // R5 iso drop
    '{1'b1,1'b0,2'd0,1'b0,1'b0,1'b1,1'b0,11'd64,11'd100,2'd1,1'b0}, // R5 over stall
    '{1'b1,1'b1,2'd1,1'b0,1'b0,1'b1,1'b1,11'd8, 11'd100,2'd0,1'b1}, // R6 setup
    '{1'b0,1'b0,2'd1,1'b0,1'b0,1'b1,1'b0,11'd8, 11'd0,  2'd0,1'b1}, // R6 no room
    '{1'b0,1'b1,2'd2,1'b0,1'b0,1'b0,1'b0,11'd0, 11'd0,  2'd1,1'b0}, // R8 in nak
    '{1'b0,1'b1,2'd2,1'b0,1'b1,1'b0,1'b0,11'd0, 11'd0,  2'd0,1'b0}, // R8 periodic
    '{1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0,11'd10,11'd20, 2'd0,1'b1}, // R8 out free
    '{1'b0,1'b0,2'd2,1'b0,1'b0,1'b1,1'b1,11'd0, 11'd0,  2'd2,1'b0}, // R9 stall
    '{1'b0,1'b0,2'd2,1'b0,1'b0,1'b0,1'b1,11'd0, 11'd0,  2'd1,1'b0}, // R9 nak
    '{1'b0,1'b0,2'd2,1'b0,1'b0,1'b0,1'b0,11'd0, 11'd100,2'd0,1'b0}, // R9 ack
    '{1'b1,1'b1,2'd2,1'b0,1'b0,1'b0,1'b0,11'd0, 11'd0,  2'd1,1'b0}  // R8 both
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] d);
    @(negedge clk);
    ctl_wr    = 1'b1;
    ctl_wdata = d;
    @(negedge clk);
    ctl_wr    = 1'b0;
    ctl_wdata = '0;
  endtask

  task automatic send_tok(input vec_t v);
    @(negedge clk);
    tok_valid    = 1'b1;
    tok_kind     = v.kind;
    tok_iso      = v.iso;
    tok_periodic = v.per;
    tok_len      = v.len;
    rx_free      = v.free;
    ep_stall     = v.st;
    ep_nak       = v.nk;
    @(negedge clk);
    tok_valid    = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 reset rdata", ctl_rdata, 32'h0);
    chk("R4 reset status", {31'b0, out_nak_on}, 32'h0);
    chk("R11 reset test_sel", {29'b0, test_sel}, 32'h0);
    chk("R12 idle resp_valid", {31'b0, resp_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      bus_write({21'b0, 1'b0, ~v.go, v.go, ~v.gi, v.gi, 7'b0});
      chk("R4 status bit", {31'b0, ctl_rdata[3]}, {31'b0, v.go});
      chk("R3 in nak state", {31'b0, in_nak_on}, {31'b0, v.gi});
      send_tok(v);
      chk("R12 resp_valid", {31'b0, resp_valid}, 32'h1);
      chk($sformatf("R5-R9 vec %0d code", i), {30'b0, resp_code}, {30'b0, v.code});
      chk($sformatf("R5-R9 vec %0d fifo_wr", i), {31'b0, resp_fifo_wr}, {31'b0, v.wr});
      @(negedge clk);
      chk("R12 resp drops", {31'b0, resp_valid}, 32'h0);
    end

    bus_write(32'hFFFF_FFFF);
    chk("R1 reserved zero and R2 clear wins", ctl_rdata, 32'h0000_0870);
    chk("R3 clear wins", {31'b0, in_nak_on}, 32'h0);
    chk("R11 reserved 7 to off", {29'b0, test_sel}, 32'h0);

    bus_write(32'h0000_0800);
    chk("R1 prog done set", ctl_rdata, 32'h0000_0800);
    bus_write(32'h0000_0000);
    chk("R1 prog done cleared", ctl_rdata, 32'h0);

    for (int c = 0; c < 8; c++) begin
      bus_write(32'(c) << 4);
      chk("R11 readback", {29'b0, ctl_rdata[6:4]}, 32'(c));
      chk("R11 test_sel", {29'b0, test_sel}, (c > 5) ? 32'h0 : 32'(c));
    end

    @(negedge clk);
    np_timeout = 1'b1;
    @(negedge clk);
    np_timeout = 1'b0;
    chk("R10 timeout raises", {31'b0, in_nak_on}, 32'h1);
    v = VECS[15];
    send_tok(v);
    chk("R10 in token nak", {30'b0, resp_code}, 32'h1);

    @(negedge clk);
    np_timeout = 1'b1;
    ctl_wr     = 1'b1;
    ctl_wdata  = 32'h0000_0100;
    @(negedge clk);
    np_timeout = 1'b0;
    ctl_wr     = 1'b0;
    ctl_wdata  = '0;
    chk("R10 clear beats timeout", {31'b0, in_nak_on}, 32'h0);

    @(negedge clk);
    ctl_wr       = 1'b1;
    ctl_wdata    = 32'h0000_0200;
    tok_valid    = 1'b1;
    tok_kind     = 2'd0;
    tok_iso      = 1'b0;
    tok_len      = 11'd4;
    rx_free      = 11'd50;
    ep_stall     = 1'b0;
    ep_nak       = 1'b0;
    @(negedge clk);
    ctl_wr    = 1'b0;
    tok_valid = 1'b0;
    chk("R12 old state used", {30'b0, resp_code}, 32'h0);
    chk("R12 old state fifo_wr", {31'b0, resp_fifo_wr}, 32'h1);
    chk("R2 set took effect", {31'b0, out_nak_on}, 32'h1);

    bus_write(32'h0000_0600);
    chk("R2 both strobes clear", {31'b0, out_nak_on}, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule